// File: doc/BRIEF.md
# Serial Adapter Bus Glue: Address Decode, DMA Request Routing and Interrupt Select

This block is the glue logic that sits between an I/O bus and a dual-channel serial controller on an adapter that occupies an eight-byte window of I/O space. It compares the upper address bits with a static base setting, sends the lower four offsets of the window to the serial controller, and keeps two local byte registers: a communications register at offset 4 and a configuration register at offset 5. Offsets 6 and 7 are reserved and read as zero.

The configuration register decides which of the controller's request pins drives the bus transmit and receive DMA requests, and whether each request is allowed to reach the bus. A two-bit field in it picks the interrupt source and also enables it. The choices are a latched DMA terminal-count event, the serial controller's interrupt and a test-mode input. When the board is set to share its interrupt line, the output is enabled only while an interrupt is pending. The communications register drives the line-driver enables, the clock enables and the two loopback controls. Board jumpers are modelled as static inputs.

Top module: `sio_glue`

## Requirements
- R1: The window is hit when bus_addr[15:3] equals base_sw. On a hit, ctl_sel is 1 for offsets 0 to 3 and 0 for offsets 4 to 7. Writes outside the window change no register.
- R2: A read of offset 5 returns the configuration register as {2'b00, stored bits 5..0}. Reads of offsets 6 and 7, reads outside the window, and cycles with bus_rd low return 0x00.
- R3: A read of offset 4 returns {test_in, 1'b0, stored bits 5..0}. Stored bit 5 drives loop_local, bit 4 drives loop_remote, bit 3 drives rclk_en and bit 2 drives tclk_en.
- R4: tx_drv_en follows communications bit 0 when drv_tx_reg_mode is 1 and is forced to 1 otherwise. rx_drv_en follows communications bit 1 when drv_rx_reg_mode is 1 and is forced to 1 otherwise.
- R5: Configuration bit 0 picks the transmit source: 0 selects ctl_a_wreq and 1 selects ctl_a_dtrreq. dma_tx_req follows that source only while configuration bit 2 is 1, and is 0 otherwise.
- R6: Configuration bit 1 picks the receive source: 0 selects ctl_a_wreq and 1 selects ctl_b_wreq. dma_rx_req follows that source only while configuration bit 3 is 1, and is 0 otherwise.
- R7: When configuration bits 1 and 0 are both 0 and bits 3 and 2 are both 1, dma_conflict is 1 and dma_rx_req is held at 0. The transmit request is unaffected.
- R8: Configuration bits 5..4 select the interrupt source: 00 none, 01 the terminal-count latch, 10 ctl_irq, 11 test_in.
- R9: The terminal-count latch sets on a clock edge where tc_in and dma_ack are both 1. Any write to offset 5 clears it, and the clear wins over a set in the same cycle. The latch can raise an interrupt only while share_mode is 1.
- R10: With share_mode 1, irq_oe and irq_out are both 1 while an interrupt is pending and both 0 otherwise. With share_mode 0, irq_oe is always 1 and irq_out shows the pending state.
- R11: Reset clears both registers and the terminal-count latch. After reset, both DMA requests and the interrupt are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data for local registers |
| base_sw | input | 13 | Static base setting compared with address bits 15..3 |
| ctl_sel | output | 1 | Select for the serial controller (offsets 0 to 3) |
| ctl_a_wreq | input | 1 | Channel A wait/request pin |
| ctl_a_dtrreq | input | 1 | Channel A DTR/request pin |
| ctl_b_wreq | input | 1 | Channel B wait/request pin |
| ctl_irq | input | 1 | Serial controller interrupt |
| test_in | input | 1 | Test-mode input |
| tc_in | input | 1 | Bus DMA terminal count |
| dma_ack | input | 1 | DMA acknowledge for this adapter |
| share_mode | input | 1 | Interrupt sharing option |
| drv_tx_reg_mode | input | 1 | 1: transmitter enable under register control |
| drv_rx_reg_mode | input | 1 | 1: receiver enable under register control |
| dma_tx_req | output | 1 | Bus transmit DMA request |
| dma_rx_req | output | 1 | Bus receive DMA request |
| dma_conflict | output | 1 | Both directions routed to the same pin |
| irq_out | output | 1 | Interrupt level |
| irq_oe | output | 1 | Interrupt output enable (0 means high impedance) |
| tx_drv_en | output | 1 | Line transmitter enable |
| rx_drv_en | output | 1 | Line receiver enable |
| tclk_en | output | 1 | Transmit clock enable |
| rclk_en | output | 1 | Receive clock enable |
| loop_local | output | 1 | Local loopback control |
| loop_remote | output | 1 | Remote loopback control |

## Verification
The hardest case to reach is the terminal-count interrupt, because three things must line up. The latch must be set by a coincident tc_in and dma_ack, the select field must point at it, and sharing must be on. It must then also clear on a configuration write. The bench first pulses tc_in without an acknowledge, then with one, and checks that the latch holds after tc_in drops. Next it turns sharing off with the latch still set, to see the interrupt drop while irq_oe is 1. Finally it writes the configuration register and checks that the interrupt stays cleared once sharing is back on. The pin-sharing conflict is the other case that is easy to miss, and it gets its own table rows.

// File: rtl/sio_glue_pkg.sv
package sio_glue_pkg;

  localparam int unsigned OFS_COMM = 4;
  localparam int unsigned OFS_CFG  = 5;
  localparam int unsigned CTL_SPAN = 4;

  typedef enum logic [1:0] {
    IRQ_NONE = 2'b00,
    IRQ_TC   = 2'b01,
    IRQ_CTL  = 2'b10,
    IRQ_TEST = 2'b11
  } irq_sel_e;

  typedef struct packed {
    logic [1:0] irq_sel;
    logic       rx_en;
    logic       tx_en;
    logic       rx_src;
    logic       tx_src;
  } cfg_t;

  typedef struct packed {
    logic lp_local;
    logic lp_remote;
    logic rclk;
    logic tclk;
    logic rxe;
    logic txe;
  } comm_t;

endpackage

// File: rtl/sio_glue_decode.sv
module sio_glue_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned WIN_LG2 = 3,
  localparam int unsigned BASE_W = ADDR_W - WIN_LG2
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BASE_W-1:0]  base_sw,
  input  logic               wr,
  input  logic               rd,
  output logic               ctl_sel,
  output logic               comm_wr,
  output logic               cfg_wr,
  output logic               comm_rd,
  output logic               cfg_rd
);
  import sio_glue_pkg::*;

  logic               hit;
  logic [WIN_LG2-1:0] ofs;

  always_comb begin
    hit     = (addr[ADDR_W-1:WIN_LG2] == base_sw);
    ofs     = addr[WIN_LG2-1:0];
    ctl_sel = hit && (ofs < WIN_LG2'(CTL_SPAN));
    comm_wr = hit && wr && (ofs == WIN_LG2'(OFS_COMM));
    cfg_wr  = hit && wr && (ofs == WIN_LG2'(OFS_CFG));
    comm_rd = hit && rd && (ofs == WIN_LG2'(OFS_COMM));
    cfg_rd  = hit && rd && (ofs == WIN_LG2'(OFS_CFG));
  end

endmodule

// File: rtl/sio_glue_regs.sv
module sio_glue_regs
  import sio_glue_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] wdata,
  input  logic       comm_wr,
  input  logic       cfg_wr,
  input  logic       comm_rd,
  input  logic       cfg_rd,
  input  logic       test_in,
  output cfg_t       cfg_q,
  output comm_t      comm_q,
  output logic [7:0] rdata
);

  cfg_t  cfg_d;
  comm_t comm_d;
  logic  unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[7:6];

  // next state, with the write enables spelled out
  always_comb begin
    cfg_d  = cfg_q;
    comm_d = comm_q;
    if (cfg_wr)  cfg_d  = cfg_t'(wdata[5:0]);
    if (comm_wr) comm_d = comm_t'(wdata[5:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      comm_q <= '0;
    end else begin
      if (cfg_wr)  cfg_q  <= cfg_d;
      if (comm_wr) comm_q <= comm_d;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (cfg_rd)  rdata = {2'b00, cfg_q};
    if (comm_rd) rdata = {test_in, 1'b0, comm_q};
  end

endmodule

// File: rtl/sio_glue_dma.sv
module sio_glue_dma
  import sio_glue_pkg::*;
(
  input  cfg_t cfg,
  input  logic a_wreq,
  input  logic a_dtrreq,
  input  logic b_wreq,
  output logic tx_req,
  output logic rx_req,
  output logic conflict
);

  logic tx_pin;
  logic rx_pin;

  always_comb begin
    tx_pin   = cfg.tx_src ? a_dtrreq : a_wreq;
    rx_pin   = cfg.rx_src ? b_wreq   : a_wreq;
    conflict = cfg.tx_en && cfg.rx_en && !cfg.tx_src && !cfg.rx_src;
    tx_req   = cfg.tx_en && tx_pin;
    rx_req   = cfg.rx_en && rx_pin && !conflict;
  end

endmodule

// File: rtl/sio_glue_irq.sv
module sio_glue_irq
  import sio_glue_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       tc_in,
  input  logic       dma_ack,
  input  logic       cfg_wr,
  input  logic       ctl_irq,
  input  logic       test_in,
  input  logic       share_mode,
  output logic       irq_out,
  output logic       irq_oe
);

  logic tc_q;
  logic tc_d;
  logic tc_en;
  logic pending;

  always_comb begin
    tc_en = cfg_wr || (tc_in && dma_ack);
    tc_d  = !cfg_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tc_q <= 1'b0;
    else if (tc_en) tc_q <= tc_d;
  end

  always_comb begin
    unique case (irq_sel_e'(sel))
      IRQ_TC:   pending = tc_q && share_mode;
      IRQ_CTL:  pending = ctl_irq;
      IRQ_TEST: pending = test_in;
      default:  pending = 1'b0;
    endcase
    irq_out = pending;
    irq_oe  = share_mode ? pending : 1'b1;
  end

endmodule

// File: rtl/sio_glue.sv
module sio_glue
  import sio_glue_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned WIN_LG2 = 3,
  localparam int unsigned BASE_W = ADDR_W - WIN_LG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic [BASE_W-1:0] base_sw,
  output logic              ctl_sel,
  input  logic              ctl_a_wreq,
  input  logic              ctl_a_dtrreq,
  input  logic              ctl_b_wreq,
  input  logic              ctl_irq,
  input  logic              test_in,
  input  logic              tc_in,
  input  logic              dma_ack,
  input  logic              share_mode,
  input  logic              drv_tx_reg_mode,
  input  logic              drv_rx_reg_mode,
  output logic              dma_tx_req,
  output logic              dma_rx_req,
  output logic              dma_conflict,
  output logic              irq_out,
  output logic              irq_oe,
  output logic              tx_drv_en,
  output logic              rx_drv_en,
  output logic              tclk_en,
  output logic              rclk_en,
  output logic              loop_local,
  output logic              loop_remote
);

  logic  comm_wr, cfg_wr, comm_rd, cfg_rd;
  cfg_t  cfg_q;
  comm_t comm_q;

  sio_glue_decode #(.ADDR_W(ADDR_W), .WIN_LG2(WIN_LG2)) u_decode (
    .addr    (bus_addr),
    .base_sw (base_sw),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .ctl_sel (ctl_sel),
    .comm_wr (comm_wr),
    .cfg_wr  (cfg_wr),
    .comm_rd (comm_rd),
    .cfg_rd  (cfg_rd)
  );

  sio_glue_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wdata   (bus_wdata),
    .comm_wr (comm_wr),
    .cfg_wr  (cfg_wr),
    .comm_rd (comm_rd),
    .cfg_rd  (cfg_rd),
    .test_in (test_in),
    .cfg_q   (cfg_q),
    .comm_q  (comm_q),
    .rdata   (bus_rdata)
  );

  sio_glue_dma u_dma (
    .cfg      (cfg_q),
    .a_wreq   (ctl_a_wreq),
    .a_dtrreq (ctl_a_dtrreq),
    .b_wreq   (ctl_b_wreq),
    .tx_req   (dma_tx_req),
    .rx_req   (dma_rx_req),
    .conflict (dma_conflict)
  );

  sio_glue_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (cfg_q.irq_sel),
    .tc_in      (tc_in),
    .dma_ack    (dma_ack),
    .cfg_wr     (cfg_wr),
    .ctl_irq    (ctl_irq),
    .test_in    (test_in),
    .share_mode (share_mode),
    .irq_out    (irq_out),
    .irq_oe     (irq_oe)
  );

  always_comb begin
    tx_drv_en   = drv_tx_reg_mode ? comm_q.txe : 1'b1;
    rx_drv_en   = drv_rx_reg_mode ? comm_q.rxe : 1'b1;
    tclk_en     = comm_q.tclk;
    rclk_en     = comm_q.rclk;
    loop_local  = comm_q.lp_local;
    loop_remote = comm_q.lp_remote;
  end

endmodule

// File: rtl/sio_glue_chk.sv
module sio_glue_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ctl_sel,
  input logic              ctl_a_wreq,
  input logic              ctl_a_dtrreq,
  input logic              ctl_b_wreq,
  input logic              share_mode,
  input logic              drv_tx_reg_mode,
  input logic              drv_rx_reg_mode,
  input logic              dma_tx_req,
  input logic              dma_rx_req,
  input logic              dma_conflict,
  input logic              irq_out,
  input logic              irq_oe,
  input logic              tx_drv_en,
  input logic              rx_drv_en
);

  assert_ctl_low_offsets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_sel |-> (bus_addr[2] == 1'b0));

  assert_tx_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_tx_reg_mode |-> tx_drv_en);

  assert_rx_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_rx_reg_mode |-> rx_drv_en);

  assert_tx_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req |-> (ctl_a_wreq || ctl_a_dtrreq));

  assert_rx_has_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> (ctl_a_wreq || ctl_b_wreq));

  assert_conflict_blocks_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_conflict |-> !dma_rx_req);

  assert_dedicated_always_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !share_mode |-> irq_oe);

  assert_shared_drive_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    share_mode |-> (irq_oe == irq_out));

endmodule

bind sio_glue sio_glue_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sio_glue_bench.sv
module sio_glue_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_rdata;
  logic [12:0] base_sw;
  logic        ctl_sel;
  logic        ctl_a_wreq, ctl_a_dtrreq, ctl_b_wreq, ctl_irq, test_in;
  logic        tc_in, dma_ack, share_mode, drv_tx_reg_mode, drv_rx_reg_mode;
  logic        dma_tx_req, dma_rx_req, dma_conflict, irq_out, irq_oe;
  logic        tx_drv_en, rx_drv_en, tclk_en, rclk_en, loop_local, loop_remote;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sio_glue u_sio_glue (.*);

  // {cfg[3:0], a_wreq, a_dtrreq, b_wreq, exp_tx, exp_rx, exp_conflict}
  localparam logic [9:0] VEC [9] = '{
    {4'b0100, 3'b100, 3'b100},
    {4'b0101, 3'b100, 3'b000},
    {4'b0101, 3'b010, 3'b100},
    {4'b1000, 3'b100, 3'b010},
    {4'b1010, 3'b100, 3'b000},
    {4'b1010, 3'b001, 3'b010},
    {4'b1100, 3'b100, 3'b101},
    {4'b0011, 3'b111, 3'b000},
    {4'b1111, 3'b011, 3'b110}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; bus_addr = 16'h0; bus_wdata = 8'h0; bus_wr = 1'b0; bus_rd = 1'b0;
    base_sw = 13'h060; ctl_a_wreq = 0; ctl_a_dtrreq = 0; ctl_b_wreq = 0;
    ctl_irq = 0; test_in = 0; tc_in = 0; dma_ack = 0; share_mode = 0;
    drv_tx_reg_mode = 1; drv_rx_reg_mode = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(16'h0305, r); check("R11 cfg after reset", r, 8'h00);
    rd(16'h0304, r); check("R11 comm after reset", r, 8'h00);
    check("R11 dma/irq idle", {5'b0, dma_tx_req, dma_rx_req, irq_out}, 8'h00);
    check("R11 irq_oe dedicated", {7'b0, irq_oe}, 8'h01);
    check("R4 reg-mode drivers off", {6'b0, tx_drv_en, rx_drv_en}, 8'h00);

    // R5 R6 R7 routing table
    foreach (VEC[i]) begin
      wr(16'h0305, {4'b0000, VEC[i][9:6]});
      ctl_a_wreq = VEC[i][5]; ctl_a_dtrreq = VEC[i][4]; ctl_b_wreq = VEC[i][3];
      @(negedge clk);
      check($sformatf("R5 R6 R7 vector %0d", i),
            {5'b0, dma_tx_req, dma_rx_req, dma_conflict}, {5'b0, VEC[i][2:0]});
    end
    ctl_a_wreq = 0; ctl_a_dtrreq = 0; ctl_b_wreq = 0;

    // R1 decode
    wr(16'h0305, 8'h00);
    wr(16'h0705, 8'h3F);
    rd(16'h0305, r); check("R1 miss write ignored", r, 8'h00);
    @(negedge clk); bus_addr = 16'h0301; #1 check("R1 ctl_sel offset 1", {7'b0, ctl_sel}, 8'h01);
    bus_addr = 16'h0304; #1 check("R1 ctl_sel offset 4", {7'b0, ctl_sel}, 8'h00);
    bus_addr = 16'h0701; #1 check("R1 ctl_sel miss", {7'b0, ctl_sel}, 8'h00);

    // R2 readback masking
    wr(16'h0305, 8'hFF);
    rd(16'h0305, r); check("R2 cfg readback", r, 8'h3F);
    rd(16'h0306, r); check("R2 reserved offset", r, 8'h00);
    rd(16'h0705, r); check("R2 miss read", r, 8'h00);
    wr(16'h0305, 8'h00);

    // R3 comm register
    test_in = 1;
    wr(16'h0304, 8'hFF);
    rd(16'h0304, r); check("R3 comm readback", r, 8'hBF);
    wr(16'h0304, 8'h24);
    check("R3 comm outputs", {4'b0, loop_local, loop_remote, rclk_en, tclk_en}, 8'h09);
    test_in = 0;

    // R4 driver enables
    wr(16'h0304, 8'h01);
    check("R4 reg control", {6'b0, tx_drv_en, rx_drv_en}, 8'h02);
    drv_tx_reg_mode = 0; drv_rx_reg_mode = 0; #1;
    check("R4 forced on", {6'b0, tx_drv_en, rx_drv_en}, 8'h03);
    drv_tx_reg_mode = 1; drv_rx_reg_mode = 1;

    // R8 source select
    wr(16'h0305, 8'h20); ctl_irq = 1; #1;
    check("R8 ctl irq selected", {7'b0, irq_out}, 8'h01);
    ctl_irq = 0; #1; check("R8 ctl irq low", {7'b0, irq_out}, 8'h00);
    wr(16'h0305, 8'h30); test_in = 1; #1;
    check("R8 test selected", {7'b0, irq_out}, 8'h01);
    wr(16'h0305, 8'h00); ctl_irq = 1; #1;
    check("R8 disabled", {7'b0, irq_out}, 8'h00);
    ctl_irq = 0; test_in = 0;

    // R9 R10 terminal count and sharing
    share_mode = 1;
    wr(16'h0305, 8'h10);
    check("R10 shared idle", {6'b0, irq_oe, irq_out}, 8'h00);
    @(negedge clk); tc_in = 1; dma_ack = 0; @(negedge clk); tc_in = 0;
    check("R9 tc without ack", {7'b0, irq_out}, 8'h00);
    tc_in = 1; dma_ack = 1; @(negedge clk); tc_in = 0; dma_ack = 0; @(negedge clk);
    check("R9 R10 tc latched", {6'b0, irq_oe, irq_out}, 8'h03);
    share_mode = 0; #1;
    check("R9 tc needs sharing", {6'b0, irq_oe, irq_out}, 8'h02);
    share_mode = 1;
    wr(16'h0305, 8'h10);
    check("R9 cfg write clears", {6'b0, irq_oe, irq_out}, 8'h00);
    // clear wins over simultaneous set
    @(negedge clk); bus_addr = 16'h0305; bus_wdata = 8'h10; bus_wr = 1; tc_in = 1; dma_ack = 1;
    @(negedge clk); bus_wr = 0; tc_in = 0; dma_ack = 0;
    check("R9 clear wins", {7'b0, irq_out}, 8'h00);

    // R11 mid-run reset
    wr(16'h0305, 8'h3C); wr(16'h0304, 8'h3F);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(16'h0305, r); check("R11 cfg cleared", r, 8'h00);
    rd(16'h0304, r); check("R11 comm cleared", r, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule